// File: doc/BRIEF.md
# Monitor Sense Line Sequencer

This block reads the identification wiring of a display connector that has three open-drain sense lines, named A, B and C. It runs a fixed probe sequence. First it pulls all three lines high for a short precharge. Then it lets them float and reads them. Then it pulls each line low in turn and reads how the other two respond. Every read happens at the end of a programmable settle time. The selected levels are packed into an 11-bit identification code. Software or a mode-selection block can translate that code into a display type.

The probe starts with a one-cycle start pulse. For the whole sequence the block reports busy. When the code is valid it raises done for a single cycle, and it holds the code until the next sequence completes. Each line has two output bits: an enable, where 1 means the driver is on, and a level. The pad logic turns these into open-drain behaviour. The line levels come back on a 3-bit input, which is asynchronous. The block resynchronises that input internally before it reads it.

Top module: `sense_seq_top`

## Requirements
- R1: On a synchronous active-high reset, busy and done go to 0, the code goes to 0, and all three drivers are off (line_en = 000). A reset during a sequence aborts it without a done pulse.
- R2: A start pulse while idle makes busy 1 from the next cycle on. The first step drives all three lines high (line_en = 111, line_lvl = 111) for exactly SHORT_WAIT cycles. In all vectors, bit 2 is line A, bit 1 is line B and bit 0 is line C.
- R3: The second step turns all drivers off for LONG_WAIT cycles. The {A,B,C} levels read at its end are stored in code bits 10..8.
- R4: The third step drives only A, and drives it low (line_en = 100, line_lvl = 011), for LONG_WAIT cycles. The {B,C} levels read at its end are stored in code bits 5..4.
- R5: The fourth step drives only B, and drives it low (line_en = 010, line_lvl = 101), for LONG_WAIT cycles. Level A goes to code bit 3 and level C goes to code bit 2.
- R6: The fifth step drives only C, and drives it low (line_en = 001, line_lvl = 110), for LONG_WAIT cycles. The {A,B} levels go to code bits 1..0.
- R7: Code bits 7..6 are always 0.
- R8: At the end of the sequence, all drivers turn off and busy falls. In the same cycle, done is 1 for exactly one cycle and the new code appears. Busy lasts exactly SHORT_WAIT + 4*LONG_WAIT cycles. The code stays unchanged until the next done.
- R9: A start pulse while busy is ignored. The sequence keeps its length and produces only one done.
- R10: The lines are read only in the last cycle of each sampling step. A level change that settles again before that cycle has no effect on the code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to run the probe sequence |
| line_in | input | 3 | Asynchronous sense line levels {A,B,C} |
| line_en | output | 3 | Per-line driver enable, 1 = driving |
| line_lvl | output | 3 | Per-line driven level |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when the code is updated |
| sense_code | output | 11 | Packed identification code |

## Verification
The assertions assume that start is synchronous to clk. They also assume that the external wiring lets line_in settle well within LONG_WAIT cycles after a drive change, so that the sample taken in the last cycle of a step sees settled levels. The bench feeds line_in from a model of the connector that responds at once to line_en and line_lvl. It uses settle parameters much larger than the two-flop synchroniser delay. It applies glitches only early in a step, well away from the sampling cycle. Start pulses and resets are driven on the falling edge, so they are always cleanly synchronous.

// File: rtl/sense_seq_pkg.sv
package sense_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_PRECHG  = 3'd1,
    ST_FLOAT   = 3'd2,
    ST_LOW_A   = 3'd3,
    ST_LOW_B   = 3'd4,
    ST_LOW_C   = 3'd5
  } step_t;

  // control word: [5:3] per-line driver off (1 = released), [2:0] level
  localparam logic [5:0] CTL_PRECHG = 6'o07;
  localparam logic [5:0] CTL_OFF    = 6'o77;
  localparam logic [5:0] CTL_LOW_A  = 6'o33;
  localparam logic [5:0] CTL_LOW_B  = 6'o55;
  localparam logic [5:0] CTL_LOW_C  = 6'o66;

  function automatic logic [5:0] ctl_of(input step_t s);
    case (s)
      ST_PRECHG: ctl_of = CTL_PRECHG;
      ST_LOW_A:  ctl_of = CTL_LOW_A;
      ST_LOW_B:  ctl_of = CTL_LOW_B;
      ST_LOW_C:  ctl_of = CTL_LOW_C;
      default:   ctl_of = CTL_OFF;
    endcase
  endfunction

  function automatic step_t next_of(input step_t s);
    case (s)
      ST_PRECHG: next_of = ST_FLOAT;
      ST_FLOAT:  next_of = ST_LOW_A;
      ST_LOW_A:  next_of = ST_LOW_B;
      ST_LOW_B:  next_of = ST_LOW_C;
      default:   next_of = ST_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/sense_sync.sv
module sense_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[0] <= '0;
          else     stg[0] <= d;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) stg[i] <= '0;
          else     stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sense_wait_cnt.sv
module sense_wait_cnt #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (load)      cnt <= load_val;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  // counter must never wrap: a load is followed by a strictly decreasing value
  p_cnt_no_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (!load && !zero) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/sense_fsm.sv
module sense_fsm
  import sense_seq_pkg::*;
#(
  parameter int SHORT_WAIT = 200,
  parameter int LONG_WAIT  = 2000,
  parameter int CW         = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          cnt_zero,
  output logic          cnt_load,
  output logic [CW-1:0] cnt_val,
  output logic [5:0]    ctl,
  output logic          busy,
  output logic          done,
  output logic          strobe,
  output step_t         step
);
  localparam logic [CW-1:0] SHORT_RELOAD = CW'(SHORT_WAIT - 1);
  localparam logic [CW-1:0] LONG_RELOAD  = CW'(LONG_WAIT - 1);

  step_t state;
  logic  launch, advance, last_step;

  assign launch    = (state == ST_IDLE) && start;
  assign advance   = (state != ST_IDLE) && cnt_zero;
  assign last_step = (state == ST_LOW_C);

  assign cnt_load = launch || (advance && !last_step);
  assign cnt_val  = launch ? SHORT_RELOAD : LONG_RELOAD;
  assign strobe   = advance && (state != ST_PRECHG);
  assign step     = state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      ctl   <= CTL_OFF;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (launch) begin
        state <= ST_PRECHG;
        ctl   <= ctl_of(ST_PRECHG);
        busy  <= 1'b1;
      end else if (advance) begin
        state <= next_of(state);
        ctl   <= ctl_of(next_of(state));
        if (last_step) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && ctl == CTL_OFF));
  p_first_high_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (ctl == CTL_PRECHG && state == ST_PRECHG));
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && !cnt_zero) |=> (busy && $stable(state)));
endmodule

// File: rtl/sense_pack.sv
module sense_pack
  import sense_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        strobe,
  input  step_t       step,
  input  logic [2:0]  lines,
  output logic [10:0] code
);
  logic [10:0] work;
  logic        finish;

  assign finish = strobe && (step == ST_LOW_C);

  always_ff @(posedge clk) begin
    if (rst) begin
      work <= '0;
    end else if (strobe) begin
      case (step)
        ST_FLOAT: work[10:8] <= lines;
        ST_LOW_A: work[5:4]  <= lines[1:0];
        ST_LOW_B: work[3:2]  <= {lines[2], lines[0]};
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         code <= '0;
    else if (finish) code <= {work[10:8], 2'b00, work[5:2], lines[2:1]};
  end

  p_code_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !finish |=> $stable(code));
endmodule

// File: rtl/sense_seq_top.sv
module sense_seq_top
  import sense_seq_pkg::*;
#(
  parameter int SHORT_WAIT  = 200,
  parameter int LONG_WAIT   = 2000,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [2:0]  line_in,
  output logic [2:0]  line_en,
  output logic [2:0]  line_lvl,
  output logic        busy,
  output logic        done,
  output logic [10:0] sense_code
);
  localparam int MAX_WAIT = (SHORT_WAIT > LONG_WAIT) ? SHORT_WAIT : LONG_WAIT;
  localparam int CW       = $clog2(MAX_WAIT + 1);

  logic [2:0]    line_s;
  logic          cnt_zero, cnt_load, strobe;
  logic [CW-1:0] cnt_val;
  logic [5:0]    ctl;
  step_t         step;

  sense_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(line_in), .q(line_s)
  );

  sense_wait_cnt #(.W(CW)) u_cnt (
    .clk(clk), .rst(rst), .load(cnt_load), .load_val(cnt_val), .zero(cnt_zero)
  );

  sense_fsm #(.SHORT_WAIT(SHORT_WAIT), .LONG_WAIT(LONG_WAIT), .CW(CW)) u_fsm (
    .clk(clk), .rst(rst), .start(start), .cnt_zero(cnt_zero),
    .cnt_load(cnt_load), .cnt_val(cnt_val), .ctl(ctl),
    .busy(busy), .done(done), .strobe(strobe), .step(step)
  );

  sense_pack u_pack (
    .clk(clk), .rst(rst), .strobe(strobe), .step(step),
    .lines(line_s), .code(sense_code)
  );

  assign line_en  = ~ctl[5:3];
  assign line_lvl = ctl[2:0];

  p_idle_released_r8: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (line_en == 3'b000));
  p_single_low_r4: assert property (@(posedge clk) disable iff (rst)
    (busy && line_en != 3'b111 && line_en != 3'b000) |->
      ($onehot0(line_en) && (line_en & line_lvl) == 3'b000));
  p_bits_unused_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> (sense_code[7:6] == 2'b00));
endmodule

// File: tb/tb_sense_seq_top.sv
module tb_sense_seq_top;
  localparam int SHORT = 8;
  localparam int LONG  = 40;
  localparam int TOTAL = SHORT + 4 * LONG;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  line_in, line_en, line_lvl;
  logic        busy, done;
  logic [10:0] sense_code;

  logic [2:0] gnd = 3'b000;
  logic [2:0] shorts = 3'b000;  // [0] A-B, [1] B-C, [2] A-C
  logic [2:0] glitch = 3'b000;

  int n_checks = 0;
  int n_errors = 0;
  int n_done = 0;
  int cyc = 0;
  logic [10:0] exp_q[$];
  int cnt_hi, cnt_fl, cnt_a, cnt_b, cnt_c;
  logic done_prev = 1'b0;

  always #5 clk = ~clk;

  sense_seq_top #(.SHORT_WAIT(SHORT), .LONG_WAIT(LONG)) dut (
    .clk(clk), .rst(rst), .start(start), .line_in(line_in),
    .line_en(line_en), .line_lvl(line_lvl), .busy(busy), .done(done),
    .sense_code(sense_code)
  );

  function automatic logic [2:0] model(input logic [2:0] en, input logic [2:0] lv,
                                       input logic [2:0] g, input logic [2:0] s,
                                       input logic [2:0] gl);
    logic [2:0] r;
    logic [2:0] pl;
    pl = en & ~lv;  // lines being driven low
    for (int i = 0; i < 3; i++) begin
      if (en[i]) r[i] = lv[i];
      else       r[i] = !g[i];
    end
    // A=2, B=1, C=0
    if (!en[2] && ((s[0] && pl[1]) || (s[2] && pl[0]))) r[2] = 1'b0;
    if (!en[1] && ((s[0] && pl[2]) || (s[1] && pl[0]))) r[1] = 1'b0;
    if (!en[0] && ((s[1] && pl[1]) || (s[2] && pl[2]))) r[0] = 1'b0;
    model = r & ~gl;
  endfunction

  assign line_in = model(line_en, line_lvl, gnd, shorts, glitch);

  function automatic logic [10:0] exp_code(input logic [2:0] g, input logic [2:0] s);
    logic [2:0] f, a, b, c;
    f = model(3'b000, 3'b111, g, s, 3'b000);
    a = model(3'b100, 3'b011, g, s, 3'b000);
    b = model(3'b010, 3'b101, g, s, 3'b000);
    c = model(3'b001, 3'b110, g, s, 3'b000);
    exp_code = {f, 2'b00, a[1:0], b[2], b[0], c[2:1]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst) begin
      cnt_hi = 0; cnt_fl = 0; cnt_a = 0; cnt_b = 0; cnt_c = 0;
    end else begin
      if (busy) begin
        case ({line_en, line_lvl})
          6'b111_111: cnt_hi++;
          6'b000_111: cnt_fl++;
          6'b100_011: cnt_a++;
          6'b010_101: cnt_b++;
          6'b001_110: cnt_c++;
          default: chk("R2 drive pattern", {26'd0, line_en, line_lvl}, 32'd0);
        endcase
      end
      if (done_prev) chk("R8 done one cycle", {31'd0, done}, 32'd0);
      if (done) begin
        logic [10:0] e;
        n_done++;
        chk("R8 busy low at done", {31'd0, busy}, 32'd0);
        chk("R8 released at done", {29'd0, line_en}, 32'd0);
        chk("R2 precharge length", cnt_hi, SHORT);
        chk("R3 float length", cnt_fl, LONG);
        chk("R4 A-low length", cnt_a, LONG);
        chk("R5 B-low length", cnt_b, LONG);
        chk("R6 C-low length", cnt_c, LONG);
        cnt_hi = 0; cnt_fl = 0; cnt_a = 0; cnt_b = 0; cnt_c = 0;
        if (exp_q.size() == 0) begin
          chk("R9 unexpected done", 32'd1, 32'd0);
        end else begin
          e = exp_q.pop_front();
          chk("R3 code[10:8]", {29'd0, sense_code[10:8]}, {29'd0, e[10:8]});
          chk("R7 code[7:6]", {30'd0, sense_code[7:6]}, 32'd0);
          chk("R4 code[5:4]", {30'd0, sense_code[5:4]}, {30'd0, e[5:4]});
          chk("R5 code[3:2]", {30'd0, sense_code[3:2]}, {30'd0, e[3:2]});
          chk("R6 code[1:0]", {30'd0, sense_code[1:0]}, {30'd0, e[1:0]});
        end
      end
      done_prev = done;
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_errors++;
      $display("FAIL watchdog actual=%0d expected<=100000", cyc);
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // mode: 0 plain, 1 glitch early in float step (R10), 2 extra start while busy (R9)
  task automatic run_seq(input logic [2:0] g, input logic [2:0] s, input int mode);
    int waited;
    gnd = g; shorts = s;
    @(negedge clk);
    exp_q.push_back(exp_code(g, s));
    pulse_start();
    waited = 0;
    if (mode == 1) begin
      repeat (SHORT + 2) @(negedge clk);
      glitch = 3'b111;  // R10: glitch far from the sampling cycle
      repeat (5) @(negedge clk);
      glitch = 3'b000;
      waited = SHORT + 7;
    end else if (mode == 2) begin
      repeat (20) @(negedge clk);
      pulse_start();  // R9
      repeat (60) @(negedge clk);
      pulse_start();  // R9
      waited = 82;
    end
    repeat (TOTAL + 3 - waited) @(negedge clk);
    chk("R8 sequence ended", {31'd0, busy}, 32'd0);
  endtask

  initial begin
    int dn;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 done", {31'd0, done}, 32'd0);
    chk("R1 code", {21'd0, sense_code}, 32'd0);
    chk("R1 released", {29'd0, line_en}, 32'd0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    run_seq(3'b000, 3'b000, 0);   // no monitor wiring
    run_seq(3'b111, 3'b000, 0);   // all grounded
    run_seq(3'b010, 3'b000, 0);   // B grounded
    run_seq(3'b000, 3'b001, 0);   // A-B shorted
    run_seq(3'b000, 3'b010, 1);   // B-C shorted, glitch
    run_seq(3'b100, 3'b010, 2);   // A grounded, B-C short, extra starts
    run_seq(3'b000, 3'b100, 0);   // A-C shorted
    chk("R8 code held while idle", {21'd0, sense_code}, {21'd0, exp_code(3'b000, 3'b100)});
    repeat (30) @(negedge clk);
    chk("R8 code still held", {21'd0, sense_code}, {21'd0, exp_code(3'b000, 3'b100)});

    // R1: reset during a sequence aborts it with no done
    dn = n_done;
    gnd = 3'b001; shorts = 3'b000;
    pulse_start();
    repeat (SHORT + 10) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R1 abort busy", {31'd0, busy}, 32'd0);
    chk("R1 abort released", {29'd0, line_en}, 32'd0);
    chk("R1 abort code", {21'd0, sense_code}, 32'd0);
    rst = 1'b0;
    repeat (TOTAL) @(negedge clk);
    chk("R1 no done after abort", n_done, dn);

    run_seq(3'b001, 3'b001, 0);   // normal after abort
    chk("R9 done count matches", n_done, 8);
    chk("R9 queue drained", exp_q.size(), 0);

    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end
endmodule